// File: doc/BRIEF.md
# Delayed store write pipeline

This block sits in front of a single-ported cache data array in a five-stage pipeline. Without it, a store hit takes two memory-stage cycles: one for the tag check and one for the data write. With it, a store that hits is parked in a one-entry deferred-write register, and the next store's tag-check cycle is used to write that parked entry into the array. Each store hit therefore occupies the memory stage for a single cycle.

A load reads the array in its one cycle. If its word address matches the parked entry, the bytes the parked store enabled come from the entry and the rest come from the array. A store that misses leaves the parked entry in place. On an idle cycle, a flush request drains the entry into the array. The tag RAM, miss handling and refill sit outside this block. `tag_hit` is the combinational result of the current request's tag lookup. `arr_rdata` is the array's combinational read of `arr_addr`.

Top module: `store_defer_buf`

## Requirements
- R1: After reset the parked entry is empty, so neither an idle flush cycle nor the first store cycle asserts `arr_we`.
- R2: In a store cycle (`req_valid`=1, `req_store`=1) with a parked entry, `arr_we`=1 and `arr_addr`, `arr_wdata` and `arr_be` carry the parked entry's word address, data and byte enables. This holds whether the store hits or misses.
- R3: A store cycle with `tag_hit`=1 parks its address, data and byte enables at the clock edge, replacing any earlier entry.
- R4: A store cycle with `tag_hit`=0 leaves the parked entry unchanged and valid.
- R5: In a load cycle (`req_valid`=1, `req_store`=0) whose `req_addr` equals the parked address, byte i of `load_data` (bits 8i+7..8i) is the parked data byte when parked enable bit i is 1. Otherwise that byte is the `arr_rdata` byte.
- R6: In a load cycle with no match, `arr_addr` equals `req_addr` and `load_data` equals `arr_rdata`.
- R7: An idle cycle (`req_valid`=0) with `flush`=1 and a parked entry writes that entry to the array and empties the parked slot. A second such cycle then writes nothing.
- R8: `flush` has no effect while `req_valid`=1: the entry is not cleared.
- R9: A load cycle never asserts `arr_we`.
- R10: An idle cycle with `flush`=0 does not assert `arr_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A memory-stage request is present |
| req_store | input | 1 | 1 for store, 0 for load |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Store data |
| req_be | input | DW/8 | Store byte enables |
| tag_hit | input | 1 | Tag lookup result for this request |
| flush | input | 1 | Drain the parked entry on an idle cycle |
| arr_addr | output | AW | Data-array word address |
| arr_we | output | 1 | Data-array write enable |
| arr_wdata | output | DW | Data-array write data |
| arr_be | output | DW/8 | Data-array byte write enables |
| arr_rdata | input | DW | Data-array read data for arr_addr |
| load_data | output | DW | Load result returned to the CPU |

## Verification
The bench builds the block with AW=6 and DW=32, which gives four byte lanes. Random addresses are drawn from only eight words, so loads hit the parked word often. Back-to-back partial stores to the same word, merges of those stores with array data, and drains between them all occur many times within a few thousand cycles. A behavioural architectural memory, updated at once on every store hit, checks every load end to end through the bench's own array model.

// File: rtl/store_defer_buf.sv
module store_defer_buf #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_store,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW/8-1:0] req_be,
  input  logic          tag_hit,
  input  logic          flush,
  output logic [AW-1:0] arr_addr,
  output logic          arr_we,
  output logic [DW-1:0] arr_wdata,
  output logic [DW/8-1:0] arr_be,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] load_data
);
  localparam int BW = DW / 8;

  logic          pv;
  logic [AW-1:0] pa;
  logic [DW-1:0] pd;
  logic [BW-1:0] pb;

  wire is_st  = req_valid & req_store;
  wire is_ld  = req_valid & ~req_store;
  wire drain  = ~req_valid & flush;
  wire park   = is_st & tag_hit;
  wire match  = pv & (req_addr == pa);

  assign arr_we    = pv & (is_st | drain);
  assign arr_addr  = is_ld ? req_addr : pa;
  assign arr_wdata = pd;
  assign arr_be    = pb;

  for (genvar i = 0; i < BW; i++) begin : g_lane
    assign load_data[8*i +: 8] = (match & pb[i]) ? pd[8*i +: 8] : arr_rdata[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     pv <= 1'b0;
    else if (park)  pv <= 1'b1;
    else if (drain) pv <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (park) begin
      pa <= req_addr;
      pd <= req_wdata;
      pb <= req_be;
    end
  end
endmodule

module store_defer_buf_chk #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_store,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic [DW/8-1:0] req_be,
  input logic          tag_hit,
  input logic          flush,
  input logic [AW-1:0] arr_addr,
  input logic          arr_we,
  input logic [DW-1:0] arr_wdata,
  input logic [DW-1:0] load_data
);
  p_load_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store) |-> !arr_we);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !flush) |-> !arr_we);

  p_store_drains_prev_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && $past(req_valid && req_store && tag_hit && rst_n))
      |-> (arr_we && arr_addr == $past(req_addr) && arr_wdata == $past(req_wdata)));

  p_double_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && flush && $past(!req_valid && flush && rst_n)) |-> !arr_we);

  p_forward_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && $past(req_valid && req_store && tag_hit && rst_n)
      && req_addr == $past(req_addr) && (&$past(req_be)))
      |-> load_data == $past(req_wdata));
endmodule

bind store_defer_buf store_defer_buf_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
  .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .tag_hit(tag_hit),
  .flush(flush), .arr_addr(arr_addr), .arr_we(arr_we), .arr_wdata(arr_wdata),
  .load_data(load_data)
);

// File: tb/tb_store_defer_buf.sv
module tb_store_defer_buf;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, tag_hit = 1'b0, flush = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [BW-1:0] req_be = '0;
  logic [AW-1:0] arr_addr;
  logic arr_we;
  logic [DW-1:0] arr_wdata, arr_rdata, load_data;
  logic [BW-1:0] arr_be;

  always #10 clk = ~clk;

  store_defer_buf #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .tag_hit(tag_hit),
    .flush(flush), .arr_addr(arr_addr), .arr_we(arr_we), .arr_wdata(arr_wdata),
    .arr_be(arr_be), .arr_rdata(arr_rdata), .load_data(load_data)
  );

  logic [DW-1:0] arr_mem [NW];
  logic [DW-1:0] ref_mem [NW];
  assign arr_rdata = arr_mem[arr_addr];

  always @(posedge clk)
    if (arr_we)
      for (int i = 0; i < BW; i++)
        if (arr_be[i]) arr_mem[arr_addr][8*i +: 8] <= arr_wdata[8*i +: 8];

  bit m_pv = 0;
  logic [AW-1:0] m_pa;
  logic [DW-1:0] m_pd;
  logic [BW-1:0] m_pb;
  int vectors = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit st, int a, logic [DW-1:0] d, logic [BW-1:0] be, bit hit, bit fl, string tag0 = "");
    string tag;
    bit exp_we;
    @(negedge clk);
    req_valid = v; req_store = st; req_addr = AW'(a); req_wdata = d;
    req_be = be; tag_hit = hit; flush = fl;
    #5;
    exp_we = m_pv && ((v && st) || (!v && fl));
    if (tag0 != "") tag = tag0;
    else if (v && st) tag = "R2";
    else if (v) tag = "R9";
    else if (fl) tag = "R7";
    else tag = "R10";
    chk(tag, "arr_we", DW'(arr_we), DW'(exp_we));
    if (exp_we) begin
      chk(tag, "arr_addr", DW'(arr_addr), DW'(m_pa));
      chk(tag, "arr_wdata", arr_wdata, m_pd);
      chk(tag, "arr_be", DW'(arr_be), DW'(m_pb));
    end
    if (v && !st) begin
      chk(m_pv && m_pa == AW'(a) ? "R5" : "R6", "load_data", load_data, ref_mem[a]);
      chk("R6", "arr_addr", DW'(arr_addr), DW'(a));
    end
    @(posedge clk);
    if (v && st && hit) begin
      for (int i = 0; i < BW; i++) if (be[i]) ref_mem[a][8*i +: 8] = d[8*i +: 8];
      m_pv = 1; m_pa = AW'(a); m_pd = d; m_pb = be;
    end else if (!v && fl) m_pv = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      arr_mem[i] = 32'h9E37_79B1 * (i + 1);
      ref_mem[i] = arr_mem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: empty after reset
    step(0, 0, 0, 0, 0, 0, 1, "R1");
    step(1, 1, 3, 32'hA1A2_A3A4, 4'hF, 0, 0, "R1");
    // R3: park a full-word store hit; R5 forward it
    step(1, 1, 3, 32'hCAFE_F00D, 4'hF, 1, 0, "R3");
    step(1, 0, 3, 0, 0, 0, 0);
    step(1, 0, 4, 0, 0, 0, 0);
    // R4: store miss keeps the entry
    step(1, 1, 5, 32'h1111_1111, 4'hF, 0, 0, "R4");
    step(1, 0, 3, 0, 0, 0, 0, "R4");
    step(1, 0, 5, 0, 0, 0, 0, "R4");
    // partial store hit: drains word 3, merge on load
    step(1, 1, 2, 32'h00BB_00DD, 4'b0101, 1, 0, "R2");
    step(1, 0, 2, 0, 0, 0, 0, "R5");
    step(1, 0, 3, 0, 0, 0, 0, "R6");
    // R8: flush with a request pending is ignored
    step(1, 0, 7, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 0, 0, 1, "R7");
    step(1, 0, 2, 0, 0, 0, 0, "R7");
    step(1, 1, 2, 32'h7777_7777, 4'b1000, 1, 1, "R8");
    step(1, 0, 2, 0, 0, 0, 0, "R8");
    // random mix over a small address window
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 9);
      int a = $urandom_range(0, 7);
      if (r < 4)      step(1, 1, a, $urandom, BW'($urandom), ($urandom_range(0, 3) != 0), r[0]);
      else if (r < 8) step(1, 0, a, 0, 0, 0, r[0]);
      else            step(0, 0, 0, 0, 0, 0, r == 9);
    end
    finish_run();
  end
endmodule